// File: doc/BRIEF.md
# PHY Link Status Poller

This block is the management master that keeps a switch's per-port operating modes in step with its attached PHYs. It produces a slow management clock from the system clock. It reads one status register from each PHY in turn with serial read frames. From the 16 returned bits it decodes link state, 100 Mbit/s versus 10 Mbit/s, and full versus half duplex. It holds the result in per-port mode outputs that the port MACs consume.

PHY vendors place the speed and duplex indications in different registers and bits. For this reason, the register number to read and the bit positions of link, speed and duplex are inputs. A further input flips the mapping from port number to PHY address. When polling is switched off, no frames are sent and each port takes its mode from static force inputs. The bidirectional data line appears as a separate output value, an output enable, and an input.

Top module: `mgmt_status_poller`

## Requirements
- R1: While rst_ni is low, mdc_o, mdio_oe_o and every bit of link_o, fast_o and full_o are 0.
- R2: While polling is enabled, every high phase and every low phase of mdc_o lasts HALF_DIV system clocks. One clock after poll_en_i is seen low, mdc_o is low and mdio_oe_o is 0.
- R3: Each frame is 64 MDC periods long and begins with 32 ones, then the start bits 0,1, then the read code 1,0, then the 5-bit PHY address and then the 5-bit register address stat_reg_i, both sent most significant bit first. The driven value changes only while mdc_o is low.
- R4: mdio_oe_o is 1 for the first 46 bit periods of a frame and 0 for the last 18: two turnaround periods and then 16 data periods. The data bits are sampled from mdio_i at the rising MDC edge, most significant bit first.
- R5: For the polled port, link_o takes data bit link_bit_i, fast_o takes bit spd_bit_i (1 means 100 Mbit/s), and full_o takes bit dpx_bit_i (1 means full duplex).
- R6: Frames poll ports 0,1,...,NPORTS-1 and then wrap to 0. The polled port's outputs update on the clock edge where MDC falls at the end of the frame, and no other port's outputs change.
- R7: With rev_order_i at 0, port p is read from PHY address p. With rev_order_i at 1, it is read from PHY address NPORTS-1-p.
- R8: While polling is disabled, each port p shows link_o[p] = force_link_i[p] one clock later. The mode code force_mode_i[2p+1:2p] selects 00 for 100 full, 01 for 100 half, 10 for 10 full and 11 for 10 half. A frame cut short by disabling is dropped, and polling resumes at the same port with a new frame.
- R9: While polling is enabled, force_link_i and force_mode_i have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_en_i | input | 1 | 1 runs status polling, 0 selects forced modes |
| rev_order_i | input | 1 | Reverse port to PHY address mapping |
| stat_reg_i | input | 5 | PHY register number to read |
| link_bit_i | input | 4 | Bit position of link status |
| spd_bit_i | input | 4 | Bit position of speed status |
| dpx_bit_i | input | 4 | Bit position of duplex status |
| force_link_i | input | NPORTS | Forced link state per port |
| force_mode_i | input | 2*NPORTS | Forced mode code per port |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |
| link_o | output | NPORTS | Link up per port |
| fast_o | output | NPORTS | 100 Mbit/s per port |
| full_o | output | NPORTS | Full duplex per port |

## Verification
A frame can complete, and update one port's mode from the sampled data, in the same period in which the force inputs move. The bench provokes this by randomising force_link_i and force_mode_i in the middle of polling rounds. At every frame end it judges all ports against a model that changes only the polled entry. A second collision is the disable arriving mid-frame. Here the frame must be discarded and the forced values must appear. The bench then checks that the next completed frame is for the same port it had interrupted.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;
  localparam int PRE_LEN   = 32;
  localparam int HDR_LEN   = PRE_LEN + 14;
  localparam int TA_LEN    = 2;
  localparam int DATA_LEN  = 16;
  localparam int FRAME_LEN = HDR_LEN + TA_LEN + DATA_LEN;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam logic [1:0] ST_CODE = 2'b01;
  localparam logic [1:0] RD_CODE = 2'b10;

  typedef struct packed {
    logic link;
    logic fast;
    logic full;
  } port_mode_t;

  // code[1]: 1 = 10M, code[0]: 1 = half duplex
  function automatic port_mode_t forced_mode(logic lnk, logic [1:0] code);
    port_mode_t m;
    m.link = lnk;
    m.fast = ~code[1];
    m.full = ~code[0];
    return m;
  endfunction
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF_DIV = 106
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == CNT_LAST);
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq import mdio_poll_pkg::*; #(
  parameter int NPORTS = 8,
  localparam int PORT_W = $clog2(NPORTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                rev_i,
  input  logic [4:0]          reg_addr_i,
  input  logic                mdio_i,
  output logic                mdio_o,
  output logic                mdio_oe_o,
  output logic                done_o,
  output logic [PORT_W-1:0]   port_o,
  output logic [DATA_LEN-1:0] data_o
);
  localparam logic [BIT_W-1:0]  HDR_TOP    = BIT_W'(HDR_LEN - 1);
  localparam logic [BIT_W-1:0]  DATA_FIRST = BIT_W'(HDR_LEN + TA_LEN);
  localparam logic [BIT_W-1:0]  BIT_LAST   = BIT_W'(FRAME_LEN - 1);
  localparam logic [PORT_W-1:0] PORT_LAST  = PORT_W'(NPORTS - 1);

  logic [BIT_W-1:0]    bit_q;
  logic [PORT_W-1:0]   port_q;
  logic [DATA_LEN-1:0] shift_q;
  logic                active_q;
  logic [PORT_W-1:0]   phy_num;
  logic [HDR_LEN-1:0]  hdr;
  logic                drive;

  assign phy_num   = rev_i ? (PORT_LAST - port_q) : port_q;
  assign hdr       = {{PRE_LEN{1'b1}}, ST_CODE, RD_CODE, 5'(phy_num), reg_addr_i};
  assign drive     = (bit_q <= HDR_TOP);
  assign mdio_oe_o = active_q && drive;
  assign mdio_o    = drive ? hdr[HDR_TOP - bit_q] : 1'b0;
  assign done_o    = fall_i && (bit_q == BIT_LAST);
  assign port_o    = port_q;
  assign data_o    = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= '0;
      port_q   <= '0;
      shift_q  <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= run_i;
      if (!run_i) begin
        bit_q <= '0;  // aborted frame restarts on same port
      end else begin
        if (rise_i && (bit_q >= DATA_FIRST))
          shift_q <= {shift_q[DATA_LEN-2:0], mdio_i};
        if (fall_i) begin
          if (bit_q == BIT_LAST) begin
            bit_q  <= '0;
            port_q <= (port_q == PORT_LAST) ? '0 : port_q + 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && port_q == PORT_LAST) |=> (port_q == '0));
endmodule

// File: rtl/port_mode_table.sv
module port_mode_table import mdio_poll_pkg::*; #(
  parameter int NPORTS = 8,
  localparam int PORT_W = $clog2(NPORTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                poll_en_i,
  input  logic                done_i,
  input  logic [PORT_W-1:0]   port_i,
  input  logic [DATA_LEN-1:0] data_i,
  input  logic [3:0]          link_bit_i,
  input  logic [3:0]          spd_bit_i,
  input  logic [3:0]          dpx_bit_i,
  input  logic [NPORTS-1:0]   force_link_i,
  input  logic [2*NPORTS-1:0] force_mode_i,
  output logic [NPORTS-1:0]   link_o,
  output logic [NPORTS-1:0]   fast_o,
  output logic [NPORTS-1:0]   full_o
);
  port_mode_t mode_q [NPORTS];
  port_mode_t polled;

  assign polled.link = data_i[link_bit_i];
  assign polled.fast = data_i[spd_bit_i];
  assign polled.full = data_i[dpx_bit_i];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q[p] <= '0;
      else if (!poll_en_i)
        mode_q[p] <= forced_mode(force_link_i[p], force_mode_i[2*p +: 2]);
      else if (done_i && port_i == PORT_W'(p))
        mode_q[p] <= polled;
    end
    assign link_o[p] = mode_q[p].link;
    assign fast_o[p] = mode_q[p].fast;
    assign full_o[p] = mode_q[p].full;
  end

  a_r6_single_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_en_i && $past(poll_en_i)) |->
      ($countones((link_o ^ $past(link_o)) | (fast_o ^ $past(fast_o)) |
                  (full_o ^ $past(full_o))) <= 1));

  a_r8_forced_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(poll_en_i)) |-> (link_o == $past(force_link_i)));
endmodule

// File: rtl/mgmt_status_poller.sv
module mgmt_status_poller import mdio_poll_pkg::*; #(
  parameter int NPORTS   = 8,
  parameter int HALF_DIV = 106
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                poll_en_i,
  input  logic                rev_order_i,
  input  logic [4:0]          stat_reg_i,
  input  logic [3:0]          link_bit_i,
  input  logic [3:0]          spd_bit_i,
  input  logic [3:0]          dpx_bit_i,
  input  logic [NPORTS-1:0]   force_link_i,
  input  logic [2*NPORTS-1:0] force_mode_i,
  output logic                mdc_o,
  output logic                mdio_o,
  output logic                mdio_oe_o,
  input  logic                mdio_i,
  output logic [NPORTS-1:0]   link_o,
  output logic [NPORTS-1:0]   fast_o,
  output logic [NPORTS-1:0]   full_o
);
  localparam int PORT_W = $clog2(NPORTS);

  logic                mdc_rise, mdc_fall, frame_done;
  logic [PORT_W-1:0]   frame_port;
  logic [DATA_LEN-1:0] frame_data;

  mdc_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (poll_en_i),
    .mdc_o (mdc_o),
    .rise_o(mdc_rise),
    .fall_o(mdc_fall)
  );

  mdio_frame_seq #(.NPORTS(NPORTS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (poll_en_i),
    .rise_i    (mdc_rise),
    .fall_i    (mdc_fall),
    .rev_i     (rev_order_i),
    .reg_addr_i(stat_reg_i),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (frame_done),
    .port_o    (frame_port),
    .data_o    (frame_data)
  );

  port_mode_table #(.NPORTS(NPORTS)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .poll_en_i   (poll_en_i),
    .done_i      (frame_done),
    .port_i      (frame_port),
    .data_i      (frame_data),
    .link_bit_i  (link_bit_i),
    .spd_bit_i   (spd_bit_i),
    .dpx_bit_i   (dpx_bit_i),
    .force_link_i(force_link_i),
    .force_mode_i(force_mode_i),
    .link_o      (link_o),
    .fast_o      (fast_o),
    .full_o      (full_o)
  );

  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_en_i |=> (!mdc_o && !mdio_oe_o));

  a_r3_drive_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe_o && $past(mdio_oe_o) && (mdio_o != $past(mdio_o))) |-> !mdc_o);

  a_r4_release_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> !mdc_o);
endmodule

// File: tb/mgmt_status_poller_test.sv
module mgmt_status_poller_test;
  localparam int N = 8;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_en = 1'b0, rev = 1'b0;
  logic [4:0] stat_reg = '0;
  logic [3:0] lbit = '0, sbit = '0, dbit = '0;
  logic [N-1:0] flink = '0;
  logic [2*N-1:0] fmode = '0;
  logic mdio_in = 1'b1;
  logic mdc, mdio_out, mdio_oe;
  logic [N-1:0] link, fast, full;

  mgmt_status_poller #(.NPORTS(N), .HALF_DIV(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .poll_en_i(poll_en), .rev_order_i(rev),
    .stat_reg_i(stat_reg), .link_bit_i(lbit), .spd_bit_i(sbit), .dpx_bit_i(dbit),
    .force_link_i(flink), .force_mode_i(fmode), .mdc_o(mdc), .mdio_o(mdio_out),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in), .link_o(link), .fast_o(fast), .full_o(full)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycles = 0, frames = 0, bp = 0;
  bit wd = 1'b0;
  logic [15:0] resp [N];
  logic [N-1:0] e_link = '0, e_fast = '0, e_full = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) wd <= 1'b1;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [45:0] exp_hdr(int port);
    logic [4:0] phy;
    phy = rev ? 5'(N - 1 - port) : 5'(port);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, phy, stat_reg};
  endfunction

  task automatic check_outputs(string tag);
    chk({link, fast, full} == {e_link, e_fast, e_full}, tag,
        32'({link, fast, full}), 32'({e_link, e_fast, e_full}));
  endtask

  // PHY model and frame monitor, away from the active edge
  logic cap_d [64];
  logic cap_e [64];
  int bcnt = 0, run_len = 0, hi_len = 0, lo_len = 0;
  logic prev_mdc = 1'b0;

  always @(negedge clk) begin
    if (!rst_n || !poll_en) begin
      bcnt = 0; run_len = 0; prev_mdc = mdc; mdio_in = 1'b1;
    end else if (mdc && !prev_mdc) begin
      cap_d[bcnt] = mdio_out; cap_e[bcnt] = mdio_oe;
      lo_len = run_len; run_len = 1; prev_mdc = mdc;
    end else if (!mdc && prev_mdc) begin
      hi_len = run_len; run_len = 1; prev_mdc = mdc;
      if (bcnt == 63) begin
        logic [45:0] h;
        logic hdr_ok, oe_ok;
        logic [15:0] d;
        int phy;
        h = exp_hdr(bp);
        hdr_ok = 1'b1; oe_ok = 1'b1;
        for (int i = 0; i < 46; i++) if (cap_d[i] !== h[45-i]) hdr_ok = 1'b0;
        for (int i = 0; i < 64; i++) if (cap_e[i] !== (i < 46)) oe_ok = 1'b0;
        chk(hdr_ok, "R3/R7 read frame header", 32'(bp), 32'(h[9:0]));
        chk(oe_ok, "R4 drive enable pattern", 32'(bp), 32'd46);
        chk(hi_len == HALF && lo_len == HALF, "R2 mdc phase length",
            32'(hi_len * 256 + lo_len), 32'(HALF * 256 + HALF));
        phy = rev ? N - 1 - bp : bp;
        d = resp[phy];
        e_link[bp] = d[lbit]; e_fast[bp] = d[sbit]; e_full[bp] = d[dbit];
        check_outputs("R5/R6 port modes at frame end");
        bp = (bp + 1) % N;
        frames++;
        bcnt = 0;
      end else begin
        bcnt++;
      end
      begin
        int phy2;
        phy2 = rev ? N - 1 - bp : bp;
        mdio_in = (bcnt >= 48) ? resp[phy2][63-bcnt] : 1'b1;
      end
    end else begin
      run_len++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_frames(int n);
    int target;
    target = frames + n;
    while (frames < target && !wd) @(posedge clk);
    #1;
  endtask

  task automatic apply_forced(logic [N-1:0] l, logic [2*N-1:0] m);
    poll_en = 1'b0; flink = l; fmode = m;
    step(3);
    for (int p = 0; p < N; p++) begin
      e_link[p] = l[p]; e_fast[p] = ~m[2*p+1]; e_full[p] = ~m[2*p];
    end
    @(negedge clk);
    check_outputs("R8 forced modes");
    chk(!mdc && !mdio_oe, "R2 idle when disabled", 32'({mdc, mdio_oe}), 32'd0);
    step(1);
  endtask

  task automatic rand_resp();
    for (int i = 0; i < N; i++) resp[i] = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rand_resp();
    step(3);
    @(negedge clk);
    chk(!mdc && !mdio_oe && link == 0 && fast == 0 && full == 0, "R1 reset state",
        32'({mdc, mdio_oe, link, fast, full}), 32'd0);
    step(1);
    rst_n = 1'b1;
    step(2);

    // R8 directed codes then random
    apply_forced(8'hFF, 16'b11_10_01_00_11_10_01_00);
    apply_forced(8'h5A, 16'hE4E4);
    for (int k = 0; k < 4; k++) apply_forced(8'($urandom), 16'($urandom));

    // A: normal order, random config
    stat_reg = 5'($urandom); lbit = 4'($urandom); sbit = 4'($urandom); dbit = 4'($urandom);
    rev = 1'b0;
    poll_en = 1'b1;
    wait_frames(3);
    flink = ~flink; fmode = 16'($urandom);   // R9: ignored while polling
    step(20);
    @(negedge clk);
    check_outputs("R9 force inputs ignored while polling");
    step(1);
    wait_frames(6);

    // B: reversed order
    rand_resp();
    rev = 1'b1; stat_reg = 5'($urandom); lbit = 4'($urandom); sbit = 4'($urandom); dbit = 4'($urandom);
    apply_forced(8'($urandom), 16'($urandom));
    poll_en = 1'b1;
    wait_frames(8);

    // C: extreme data patterns and bit positions
    for (int i = 0; i < N; i++) resp[i] = (i % 2 == 0) ? 16'h0000 : 16'hFFFF;
    rev = 1'b0; lbit = 4'd15; sbit = 4'd0; dbit = 4'd7; stat_reg = 5'h1F;
    apply_forced(8'hFF, 16'hFFFF);
    poll_en = 1'b1;
    wait_frames(8);

    // D: single hot bits, then abort mid-frame (R8 resume)
    for (int i = 0; i < N; i++) resp[i] = 16'h0001 << i;
    lbit = 4'd1; sbit = 4'd2; dbit = 4'd3;
    apply_forced(8'h00, 16'h0000);
    poll_en = 1'b1;
    wait_frames(2);
    step(200);
    apply_forced(8'hC3, 16'h1B1B);
    poll_en = 1'b1;
    wait_frames(9);

    if (wd) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule